// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability and Vector Issuer

This block holds the configuration-space capability registers that let a PCI-style function report interrupts as memory writes, and it turns per-vector interrupt requests into single address/data write requests. Software sets the target address and the base data word, picks how many vectors it grants, then sets the enable bit. From then on a pulse on any request line becomes one write request on a valid/ready output. The low bits of the data word carry the vector number. A transaction layer downstream builds the actual packet from that request.

Each vector has its own mask bit and pending bit. A request for a masked vector is held as pending and is sent once the mask clears. When several vectors are waiting, they leave one at a time, lowest number first. The register port is a plain dword-indexed read/write port with combinational read data.

Top module: `msi_msg_unit`

## Requirements
- R1: After reset, dword 0 reads 0x018A0005: capability code 0x05 in bits 7:0, next pointer 0x00 in bits 15:8, and control in bits 31:16 with enable (bit 16) = 0, the requested-count exponent 5 in bits 19:17, the 64-bit flag in bit 23 and the mask-support flag in bit 24. No write request is pending.
- R2: A write to dword 0 updates only enable (bit 16) and the granted-count exponent (bits 22:20), and that field reads back as written. The exponent in use is the smaller of the written value and 5. All other bits of dword 0 are read-only.
- R3: With exponent k in use, the request carries the 16-bit data register (dword 3) with its low k bits replaced by the vector number. The address is {dword 2, dword 1} with address bits 1:0 forced to 0.
- R4: A request line whose number is 2^k or more is served as vector 2^k−1.
- R5: A request for a vector whose bit is set in the mask register (dword 4) sets that vector's bit in the pending register (dword 5) and sends nothing. Once the mask bit clears, the message is sent and the pending bit clears.
- R6: While enable is 0, request lines are ignored and no new request is issued, even for vectors already pending.
- R7: Writes to the pending register (dword 5) have no effect.
- R8: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold steady.
- R9: When several vectors wait, the lowest-numbered unmasked one is sent first, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Dword index for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_idx (combinational) |
| irq_req | input | 32 | Per-line interrupt request pulses, one message per cycle held high |
| msg_valid | output | 1 | Write request available |
| msg_ready | input | 1 | Downstream accepts the write request |
| msg_addr | output | 64 | Target address of the write |
| msg_data | output | 16 | Data of the write |

## Verification
The assertions assume that downstream can stall msg_ready for any length of time, and that software may change mask, enable and the granted count in any cycle. They rely on no ordering among these inputs. They do assume that irq_req is sampled only at clock edges. The bench therefore drives every input half a cycle away from the rising edge and makes register writes and request pulses single-cycle events. It also stalls msg_ready across several cycles while more than one vector waits, so the hold and ordering properties see contention.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam logic [7:0] CAP_CODE = 8'h05;

    // Dword layout of the register port
    localparam logic [2:0] IDX_CTRL    = 3'd0;
    localparam logic [2:0] IDX_ADDR_LO = 3'd1;
    localparam logic [2:0] IDX_ADDR_HI = 3'd2;
    localparam logic [2:0] IDX_DATA    = 3'd3;
    localparam logic [2:0] IDX_MASK    = 3'd4;
    localparam logic [2:0] IDX_PEND    = 3'd5;

    // Replace the low k bits of the base word with the vector number
    function automatic logic [15:0] merge_vec(input logic [15:0] base,
                                              input logic [2:0]  k,
                                              input logic [15:0] vec);
        logic [15:0] fld;
        fld = (16'd1 << k) - 16'd1;
        return (base & ~fld) | (vec & fld);
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter int         NUM_VEC      = 32,
    parameter int         REQ_LOG2     = 5,
    parameter bit         HAS_ADDR64   = 1'b1,
    parameter bit         HAS_VEC_MASK = 1'b1,
    parameter logic [7:0] NEXT_PTR     = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_idx,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_VEC-1:0] pend_i,
    output logic               en_o,
    output logic [2:0]         eff_k_o,
    output logic [NUM_VEC-1:0] mask_o,
    output logic [15:0]        data_o,
    output logic [63:0]        addr_o
);

    localparam logic [2:0] REQ_K = 3'(REQ_LOG2);

    typedef struct packed {
        logic               en;
        logic [2:0]         alloc;
        logic [29:0]        alo;
        logic [31:0]        ahi;
        logic [15:0]        data;
        logic [NUM_VEC-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [15:0] ctrl_w;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_idx)
                IDX_CTRL: begin
                    cfg_d.en    = cfg_wdata[16];
                    cfg_d.alloc = cfg_wdata[22:20];
                end
                IDX_ADDR_LO: cfg_d.alo = cfg_wdata[31:2];
                IDX_ADDR_HI: if (HAS_ADDR64) cfg_d.ahi = cfg_wdata;
                IDX_DATA:    cfg_d.data = cfg_wdata[15:0];
                IDX_MASK:    if (HAS_VEC_MASK) cfg_d.mask = cfg_wdata[NUM_VEC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        ctrl_w = {7'd0, HAS_VEC_MASK, HAS_ADDR64, cfg_q.alloc, REQ_K, cfg_q.en};
        case (cfg_idx)
            IDX_CTRL:    cfg_rdata = {ctrl_w, NEXT_PTR, CAP_CODE};
            IDX_ADDR_LO: cfg_rdata = {cfg_q.alo, 2'b00};
            IDX_ADDR_HI: cfg_rdata = cfg_q.ahi;
            IDX_DATA:    cfg_rdata = {16'd0, cfg_q.data};
            IDX_MASK:    cfg_rdata = 32'(cfg_q.mask);
            IDX_PEND:    cfg_rdata = HAS_VEC_MASK ? 32'(pend_i) : 32'd0;
            default:     cfg_rdata = 32'd0;
        endcase
    end

    assign en_o    = cfg_q.en;
    assign eff_k_o = (cfg_q.alloc > REQ_K) ? REQ_K : cfg_q.alloc;
    assign mask_o  = cfg_q.mask;
    assign data_o  = cfg_q.data;
    assign addr_o  = {cfg_q.ahi, cfg_q.alo, 2'b00};

    // Register state changes only through the write port
    assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    // Writes to the pending index leave every stored field untouched
    assert_pend_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_idx == IDX_PEND |=> $stable(cfg_q));

endmodule

// File: rtl/msi_vec_engine.sv
module msi_vec_engine
    import msi_pkg::*;
#(
    parameter int NUM_VEC      = 32,
    parameter int VEC_W        = 5,
    parameter bit HAS_VEC_MASK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [2:0]         eff_k_i,
    input  logic [NUM_VEC-1:0] mask_i,
    input  logic [15:0]        data_i,
    input  logic [63:0]        addr_i,
    input  logic [NUM_VEC-1:0] irq_i,
    output logic [NUM_VEC-1:0] pend_o,
    output logic               msg_valid_o,
    input  logic               msg_ready_i,
    output logic [63:0]        msg_addr_o,
    output logic [15:0]        msg_data_o
);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic               valid;
        logic [VEC_W-1:0]   vec;
        logic [15:0]        data;
        logic [63:0]        addr;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [NUM_VEC-1:0] set_v, clr_v, cand;
    logic [5:0]         top_vec;
    logic [VEC_W-1:0]   sel;
    logic               found;

    always_comb begin
        // Fold requests above the granted range onto the top vector
        top_vec = (6'd1 << eff_k_i) - 6'd1;
        set_v   = '0;
        if (en_i) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (irq_i[i]) begin
                    if (i > int'(top_vec)) set_v[top_vec[VEC_W-1:0]] = 1'b1;
                    else                   set_v[i]                  = 1'b1;
                end
            end
        end

        // Lowest-numbered unmasked pending vector wins
        cand  = eng_q.pend & ~(HAS_VEC_MASK ? mask_i : '0);
        found = 1'b0;
        sel   = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                sel   = VEC_W'(i);
            end
        end

        eng_d = eng_q;
        clr_v = '0;
        if (!eng_q.valid || msg_ready_i) begin
            eng_d.valid = 1'b0;
            if (en_i && found) begin
                eng_d.valid = 1'b1;
                eng_d.vec   = sel;
                eng_d.data  = merge_vec(data_i, eff_k_i, 16'(sel));
                eng_d.addr  = addr_i;
                clr_v[sel]  = 1'b1;
            end
        end
        eng_d.pend = (eng_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign pend_o      = eng_q.pend;
    assign msg_valid_o = eng_q.valid;
    assign msg_addr_o  = eng_q.addr;
    assign msg_data_o  = eng_q.data;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

    assert_no_issue_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid_o) |-> $past(en_i));

    assert_no_capture_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (eng_q.pend & ~$past(eng_q.pend)) == '0);

    assert_single_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_v));

    generate
        if (HAS_VEC_MASK) begin : g_mask_chk
            for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
                assert_masked_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    eng_q.pend[g] && mask_i[g] |=> eng_q.pend[g]);
            end
        end
    endgenerate

endmodule

// File: rtl/msi_msg_unit.sv
module msi_msg_unit
    import msi_pkg::*;
#(
    parameter int         REQ_LOG2     = 5,
    parameter bit         HAS_ADDR64   = 1'b1,
    parameter bit         HAS_VEC_MASK = 1'b1,
    parameter logic [7:0] NEXT_PTR     = 8'h00,
    localparam int        NUM_VEC      = 1 << REQ_LOG2,
    localparam int        VEC_W        = (REQ_LOG2 < 1) ? 1 : REQ_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_idx,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [15:0]        msg_data
);

    logic               en;
    logic [2:0]         eff_k;
    logic [NUM_VEC-1:0] mask, pend;
    logic [15:0]        base_data;
    logic [63:0]        base_addr;

    msi_cfg_regs #(
        .NUM_VEC(NUM_VEC), .REQ_LOG2(REQ_LOG2), .HAS_ADDR64(HAS_ADDR64),
        .HAS_VEC_MASK(HAS_VEC_MASK), .NEXT_PTR(NEXT_PTR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend_i(pend),
        .en_o(en), .eff_k_o(eff_k), .mask_o(mask), .data_o(base_data),
        .addr_o(base_addr)
    );

    msi_vec_engine #(
        .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .HAS_VEC_MASK(HAS_VEC_MASK)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .en_i(en), .eff_k_i(eff_k), .mask_i(mask),
        .data_i(base_data), .addr_i(base_addr), .irq_i(irq_req), .pend_o(pend),
        .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
        .msg_addr_o(msg_addr), .msg_data_o(msg_data)
    );

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[1:0] == 2'b00);

endmodule

// File: tb/msi_msg_unit_tb.sv
module msi_msg_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] irq_req;
    logic        msg_valid;
    logic        msg_ready;
    logic [63:0] msg_addr;
    logic [15:0] msg_data;

    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] BASE_DATA = 16'h1230;
    localparam logic [31:0] ADDR_LO   = 32'hFEE0_0000;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msi_msg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [15:0] exp_data(input int k, input int v);
        logic [15:0] f;
        f = (16'd1 << k) - 16'd1;
        return (BASE_DATA & ~f) | (16'(v) & f);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        cfg_idx = idx;
        #1 val = cfg_rdata;
    endtask

    task automatic pulse(input logic [31:0] lines);
        @(negedge clk);
        irq_req = lines;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic expect_none(input string req);
        int seen = 0;
        msg_ready = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        msg_ready = 1'b0;
        check(req, 64'(seen), 64'd0);
    endtask

    task automatic collect(input string req, input logic [63:0] ea, input logic [15:0] ed);
        int got = 0;
        msg_ready = 1'b1;
        for (int c = 0; c < 20 && got == 0; c++) begin
            #1;
            if (msg_valid) got = 1;
            else @(negedge clk);
        end
        check({req, " valid"}, 64'(got), 64'd1);
        check({req, " data"}, 64'(msg_data), 64'(ed));
        check({req, " addr"}, msg_addr, ea);
        @(posedge clk);
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v);
        check("R1 header", 64'(v), 64'h018A_0005);
        check("R1 idle", 64'(msg_valid), 64'd0);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        wr(3'd1, ADDR_LO);
        wr(3'd3, 32'(BASE_DATA));
        wr(3'd0, 32'h0030_0000);
        pulse(32'h0000_0008);
        expect_none("R6 no message while disabled");
        rd(3'd5, v);
        check("R6 request not captured", 64'(v), 64'd0);
    endtask

    task automatic t_basic;
        wr(3'd0, 32'h0031_0000);
        pulse(32'h0000_0020);
        collect("R3 vector 5", {32'd0, ADDR_LO}, exp_data(3, 5));
    endtask

    task automatic t_fold;
        pulse(32'h0010_0000);
        collect("R4 line 20 folds to 7", {32'd0, ADDR_LO}, exp_data(3, 7));
    endtask

    task automatic t_priority;
        logic [15:0] first;
        msg_ready = 1'b0;
        pulse(32'h0000_0044);
        @(negedge clk);
        first = msg_data;
        check("R9 lowest first", 64'(first), 64'(exp_data(3, 2)));
        for (int c = 0; c < 3; c++) @(negedge clk);
        check("R8 valid held", 64'(msg_valid), 64'd1);
        check("R8 data held", 64'(msg_data), 64'(first));
        collect("R9 vector 2 accepted", {32'd0, ADDR_LO}, exp_data(3, 2));
        collect("R9 vector 6 next", {32'd0, ADDR_LO}, exp_data(3, 6));
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(3'd4, 32'h0000_0010);
        pulse(32'h0000_0010);
        expect_none("R5 masked vector silent");
        rd(3'd5, v);
        check("R5 pending set", 64'(v), 64'h10);
        wr(3'd4, 32'h0);
        collect("R5 sent on unmask", {32'd0, ADDR_LO}, exp_data(3, 4));
        rd(3'd5, v);
        check("R5 pending cleared", 64'(v), 64'd0);
    endtask

    task automatic t_pend_ro;
        logic [31:0] v;
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v);
        check("R7 pending write ignored", 64'(v), 64'd0);
        expect_none("R7 no message from pending write");
    endtask

    task automatic t_cap;
        logic [31:0] v;
        wr(3'd0, 32'hFFF1_FFFF);
        rd(3'd0, v);
        check("R2 control writable bits only", 64'(v), 64'h01FB_0005);
        pulse(32'h0002_0000);
        collect("R2 exponent capped at 5", {32'd0, ADDR_LO}, exp_data(5, 17));
    endtask

    task automatic t_addr64;
        wr(3'd2, 32'h0000_0001);
        pulse(32'h0000_0001);
        collect("R3 64-bit address", {32'h1, ADDR_LO}, exp_data(5, 0));
    endtask

    task automatic t_disable_pending;
        wr(3'd4, 32'h0000_0002);
        pulse(32'h0000_0002);
        wr(3'd0, 32'h0050_0000);
        wr(3'd4, 32'h0);
        expect_none("R6 pending held while disabled");
        wr(3'd0, 32'h0051_0000);
        collect("R6 sent after re-enable", {32'h1, ADDR_LO}, exp_data(5, 1));
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        irq_req = '0; msg_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_basic();
        t_fold();
        t_priority();
        t_mask();
        t_pend_ro();
        t_cap();
        t_addr64();
        t_disable_pending();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule